// File: doc/BRIEF.md
# Asynchronous Character Receiver with Break Detection

This block turns a serial asynchronous line into parallel characters. A clock enable, `os_tick`, paces an oversampling counter. The number of ticks per bit is set by the `os_factor` input. While the receiver is idle it watches the line for a low level. When it sees one, it confirms the start bit half a bit period later. It then samples every following bit at the middle of its period: a programmable number of data bits (least significant first), an optional parity bit and one stop bit.

Each character is delivered as a single-cycle strobe with the data right-justified, together with a parity-error flag and a framing-error flag. A frame in which every sample is low is not reported as a character. It is reported once as a line break. After a break, the receiver does not look for a new start bit until the line has gone high again.

The input line is expected to be synchronised to `clk` already. The configuration inputs (`os_factor`, `char_len`, `par_mode`) are expected to stay stable while a frame is being received.

Top module: `serial_char_rx`

## Requirements
- R1: `char_len` selects from 1 to 8 data bits; a value of 0 acts as 1 and values above 8 act as 8. The received character appears on `char_data` right-justified, with every bit above the character length at 0.
- R2: The first data bit after the start bit lands in bit 0 of `char_data`, the next in bit 1, and so on (least significant bit first).
- R3: If the line is high again when the start bit is re-sampled, the low pulse is treated as noise: no character and no break is reported, and the receiver returns to watching for a start bit.
- R4: With a clock factor F (F of at least 2) on `os_factor`, the start bit is confirmed F/2 ticks (rounded down) after the tick that first saw the line low. Every later bit is sampled F ticks after the previous sample.
- R5: `par_mode` encodings are 0 = no parity bit, 1 = odd, 2 = even, 3 = mark (parity bit must be 1), 4 = space (parity bit must be 0). `par_err` is set when the received parity bit does not match the mode. It is never set in mode 0.
- R6: A character whose stop-bit sample is 0 is delivered with `frame_err` set, unless the frame qualifies as a break under R7.
- R7: When every data sample, the parity sample (if a parity bit is present) and the stop sample are all 0, `line_break` pulses for one cycle, `char_valid` stays low, and only one pulse is given per break event.
- R8: After a break, the receiver ignores the line until it has been seen high on a tick, and only then looks for a new start bit.
- R9: `char_valid` is high for exactly one clock cycle per character. `par_err` and `frame_err` are 0 whenever `char_valid` is 0.
- R10: While `rst` is high and after it is released, all outputs are 0 and a partly received frame is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversampling clock enable, one pulse per oversample period |
| rx_line | input | 1 | Serial input line, idle high, synchronised to `clk` |
| os_factor | input | FACTOR_W (8) | Oversamples per bit, at least 2 |
| char_len | input | LEN_W (4) | Data bits per character, 1 to 8 |
| par_mode | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 mark, 4 space |
| char_valid | output | 1 | One-cycle strobe marking a received character |
| char_data | output | DATA_W (8) | Received character, right-justified |
| par_err | output | 1 | Parity mismatch for the character on this strobe |
| frame_err | output | 1 | Stop-bit sample was 0 for the character on this strobe |
| line_break | output | 1 | One-cycle pulse marking a detected break |

## Verification
The bench builds the block with its default widths (8 data bits, an 8-bit clock-factor field). It then runs the same frame table twice on the `os_factor` port: once at 16, and once at 5. At 5, the half-bit point is rounded down, so the timing falls off centre. Each run covers every parity mode with and without an injected error, lengths of 1, 2, 3, 5, 6, 7 and 8 bits, and a zero-data frame with a low stop bit that must be a framing error rather than a break. Directed cases add a short start glitch, a long break followed by a normal frame, and a reset in the middle of a frame.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic par_err;
        logic frame_err;
        logic brk;
    } rx_verdict_t;

    // True when the mode carries a parity bit on the line.
    function automatic logic mode_has_parity(par_mode_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
    endfunction

    // ones: XOR of the data bits, pbit: sampled parity bit.
    function automatic logic parity_bad(par_mode_e m, logic ones, logic pbit);
        case (m)
            PAR_ODD:   return ~(ones ^ pbit);
            PAR_EVEN:  return ones ^ pbit;
            PAR_MARK:  return ~pbit;
            PAR_SPACE: return pbit;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scr_bit_timer.sv
module scr_bit_timer #(
    parameter int FACTOR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                arm,
    input  logic                half_sel,
    input  logic [FACTOR_W-1:0] factor,
    output logic                sample
);
    logic [FACTOR_W-1:0] cnt;
    logic [FACTOR_W-1:0] target;

    assign target = half_sel ? (factor >> 1) : factor;
    assign sample = tick && !arm && (cnt == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= FACTOR_W'(1);
        end else if (tick) begin
            if (arm || sample) begin
                cnt <= FACTOR_W'(1);
            end else begin
                cnt <= cnt + FACTOR_W'(1);
            end
        end
    end

    AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (sample && !half_sel && factor > FACTOR_W'(1)) |=> !sample); // R4

endmodule

// File: rtl/scr_char_check.sv
module scr_char_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   shreg,
    input  logic                par_smp,
    input  logic                stop_smp,
    input  scr_pkg::par_mode_e  mode,
    output scr_pkg::rx_verdict_t verdict
);
    import scr_pkg::*;

    logic has_par;
    logic ones;
    logic all_low;

    assign has_par = mode_has_parity(mode);
    assign ones    = ^shreg;
    assign all_low = (shreg == '0) && (!has_par || !par_smp) && !stop_smp;

    always_comb begin
        verdict.brk       = all_low;
        verdict.par_err   = has_par && parity_bad(mode, ones, par_smp);
        verdict.frame_err = !stop_smp;
    end

    always_comb begin
        if (!has_par) begin
            AST_NO_PARITY_ERR: assert (!verdict.par_err); // R5
        end
    end

endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
    parameter int DATA_W   = 8,
    parameter int FACTOR_W = 8,
    localparam int LEN_W   = $clog2(DATA_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                rx_line,
    input  logic [FACTOR_W-1:0] os_factor,
    input  logic [LEN_W-1:0]    char_len,
    input  logic [2:0]          par_mode,
    output logic                char_valid,
    output logic [DATA_W-1:0]   char_data,
    output logic                par_err,
    output logic                frame_err,
    output logic                line_break
);
    import scr_pkg::*;

    rx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  bit_idx;
    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W-1:0]  rj_shift;
    logic              par_smp;
    logic              smp;
    logic              arm;
    par_mode_e         mode;
    rx_verdict_t       verdict;

    assign mode     = par_mode_e'(par_mode);
    assign arm      = (state == ST_HUNT) || (state == ST_HOLD);
    assign rj_shift = LEN_W'(DATA_W) - len_eff;

    always_comb begin
        if (char_len == '0) begin
            len_eff = LEN_W'(1);
        end else if (char_len > LEN_W'(DATA_W)) begin
            len_eff = LEN_W'(DATA_W);
        end else begin
            len_eff = char_len;
        end
    end

    scr_bit_timer #(.FACTOR_W(FACTOR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .arm      (arm),
        .half_sel (state == ST_START),
        .factor   (os_factor),
        .sample   (smp)
    );

    scr_char_check #(.DATA_W(DATA_W)) u_check (
        .shreg    (shreg),
        .par_smp  (par_smp),
        .stop_smp (rx_line),
        .mode     (mode),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            shreg      <= '0;
            bit_idx    <= '0;
            par_smp    <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
            par_err    <= 1'b0;
            frame_err  <= 1'b0;
            line_break <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            char_data  <= '0;
            par_err    <= 1'b0;
            frame_err  <= 1'b0;
            line_break <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (os_tick && !rx_line) begin
                        state   <= ST_START;
                        shreg   <= '0;
                        bit_idx <= '0;
                        par_smp <= 1'b0;
                    end
                end
                ST_START: begin
                    if (smp) begin
                        state <= rx_line ? ST_HUNT : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (smp) begin
                        shreg <= {rx_line, shreg[DATA_W-1:1]};
                        if (bit_idx == len_eff - LEN_W'(1)) begin
                            state <= mode_has_parity(mode) ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + LEN_W'(1);
                        end
                    end
                end
                ST_PAR: begin
                    if (smp) begin
                        par_smp <= rx_line;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (smp) begin
                        if (verdict.brk) begin
                            line_break <= 1'b1;
                            state      <= ST_HOLD;
                        end else begin
                            char_valid <= 1'b1;
                            char_data  <= shreg >> rj_shift;
                            par_err    <= verdict.par_err;
                            frame_err  <= verdict.frame_err;
                            state      <= ST_HUNT;
                        end
                    end
                end
                ST_HOLD: begin
                    if (os_tick && rx_line) begin
                        state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    AST_RIGHT_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> ((char_data >> len_eff) == '0)); // R1
    AST_GLITCH_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && smp && rx_line) |=> (state == ST_HUNT)); // R3
    AST_BREAK_NOT_CHAR: assert property (@(posedge clk) disable iff (rst)
        !(char_valid && line_break)); // R7
    AST_BREAK_ONCE: assert property (@(posedge clk) disable iff (rst)
        line_break |=> !line_break); // R7
    AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !(os_tick && rx_line)) |=> (state == ST_HOLD)); // R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid); // R9
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !char_valid |-> !(par_err || frame_err)); // R9

endmodule

// File: tb/serial_char_rx_bench.sv
module serial_char_rx_bench;

    typedef struct packed {
        logic [3:0] len;
        logic [2:0] pm;
        logic [7:0] data;
        logic       pflip;
        logic       stopv;
        logic       eperr;
        logic       eferr;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{4'd8, 3'd0, 8'hB4, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd8, 3'd1, 8'h8C, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd8, 3'd2, 8'h71, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd7, 3'd2, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd5, 3'd3, 8'h1F, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd5, 3'd3, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd1, 3'd4, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd1, 3'd4, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd8, 3'd1, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd6, 3'd0, 8'h2A, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd3, 3'd1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd8, 3'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd3, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
        '{4'd2, 3'd2, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] os_factor = 8'd16;
    logic [3:0] char_len = 4'd8;
    logic [2:0] par_mode = 3'd0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       par_err;
    logic       frame_err;
    logic       line_break;

    int n_chk = 0;
    int n_fail = 0;
    int vcnt = 0;
    int bcnt = 0;
    int quiet_bad = 0;
    logic [7:0] last_d = '0;
    logic last_pe = 1'b0;
    logic last_fe = 1'b0;
    int tdiv = 0;

    always #2 clk = ~clk;

    serial_char_rx u_serial_char_rx (
        .clk        (clk),
        .rst        (rst),
        .os_tick    (tick),
        .rx_line    (rx_line),
        .os_factor  (os_factor),
        .char_len   (char_len),
        .par_mode   (par_mode),
        .char_valid (char_valid),
        .char_data  (char_data),
        .par_err    (par_err),
        .frame_err  (frame_err),
        .line_break (line_break)
    );

    // Oversample enable: one pulse every third clock, changed away from the active edge.
    always @(negedge clk) begin
        tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 1);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (char_valid) begin
                vcnt    = vcnt + 1;
                last_d  = char_data;
                last_pe = par_err;
                last_fe = frame_err;
            end
            if (line_break) bcnt = bcnt + 1;
            if (!char_valid && (par_err || frame_err)) quiet_bad = quiet_bad + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (int'(os_factor) * 3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int len, input logic [2:0] pm,
                              input logic pflip, input logic stopv);
        logic ones;
        logic p;
        ones = 1'b0;
        for (int i = 0; i < len; i++) ones = ones ^ d[i];
        drive_bit(1'b0);
        for (int i = 0; i < len; i++) drive_bit(d[i]);
        if (pm != 3'd0) begin
            case (pm)
                3'd1:    p = ~ones;
                3'd2:    p = ones;
                3'd3:    p = 1'b1;
                default: p = 1'b0;
            endcase
            drive_bit(p ^ pflip);
        end
        drive_bit(stopv);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic run_table(input string tag);
        for (int k = 0; k < NVEC; k++) begin
            int v0;
            v0 = vcnt;
            char_len = VECS[k].len;
            par_mode = VECS[k].pm;
            send_frame(VECS[k].data, int'(VECS[k].len), VECS[k].pm, VECS[k].pflip, VECS[k].stopv);
            check(vcnt == v0 + 1, {"R9 one strobe ", tag}, vcnt - v0, 1);
            check(last_d == VECS[k].data, {"R1 R2 R4 data ", tag}, int'(last_d), int'(VECS[k].data));
            check(last_pe == VECS[k].eperr, {"R5 parity flag ", tag}, int'(last_pe), int'(VECS[k].eperr));
            check(last_fe == VECS[k].eferr, {"R6 framing flag ", tag}, int'(last_fe), int'(VECS[k].eferr));
        end
    endtask

    initial begin
        int v0;
        int b0;
        repeat (5) @(negedge clk);
        check(!char_valid && char_data == 8'h00 && !par_err && !frame_err && !line_break,
              "R10 outputs during reset", {char_valid, par_err, frame_err, line_break}, 0);
        rst = 1'b0;
        repeat (60) @(negedge clk);
        check(vcnt == 0 && bcnt == 0, "R10 quiet after reset", vcnt + bcnt, 0);

        os_factor = 8'd16;
        run_table("F16");
        os_factor = 8'd5;
        run_table("F5");

        // R3: short low pulse must be discarded
        os_factor = 8'd16;
        char_len = 4'd8;
        par_mode = 3'd0;
        v0 = vcnt;
        b0 = bcnt;
        rx_line = 1'b0;
        repeat (9) @(negedge clk);
        rx_line = 1'b1;
        repeat (16 * 3 * 3) @(negedge clk);
        check(vcnt == v0 && bcnt == b0, "R3 glitch ignored", (vcnt - v0) + (bcnt - b0), 0);
        send_frame(8'h3A, 8, 3'd0, 1'b0, 1'b1);
        check(vcnt == v0 + 1 && last_d == 8'h3A, "R3 hunting resumes", int'(last_d), 'h3A);

        // R7 and R8: long low line, then recovery
        v0 = vcnt;
        b0 = bcnt;
        drive_bit(1'b0);
        repeat (20) drive_bit(1'b0);
        check(bcnt == b0 + 1, "R7 one break pulse", bcnt - b0, 1);
        check(vcnt == v0, "R7 no character on break", vcnt - v0, 0);
        repeat (10) drive_bit(1'b0);
        check(bcnt == b0 + 1, "R8 no rescan while low", bcnt - b0, 1);
        drive_bit(1'b1);
        drive_bit(1'b1);
        send_frame(8'h5A, 8, 3'd0, 1'b0, 1'b1);
        check(vcnt == v0 + 1 && last_d == 8'h5A, "R8 receive after break", int'(last_d), 'h5A);

        // R7 with parity enabled: all-low frame in even mode
        char_len = 4'd4;
        par_mode = 3'd2;
        b0 = bcnt;
        v0 = vcnt;
        repeat (12) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
        check(bcnt == b0 + 1 && vcnt == v0, "R7 break with parity", bcnt - b0, 1);

        // R10: reset in the middle of a frame
        char_len = 4'd8;
        par_mode = 3'd0;
        v0 = vcnt;
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);
        rst = 1'b1;
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (16 * 3 * 12) @(negedge clk);
        check(vcnt == v0, "R10 frame discarded by reset", vcnt - v0, 0);

        check(quiet_bad == 0, "R9 flags only with strobe", quiet_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule